// File: doc/BRIEF.md
# Address-Collision Busy Arbiter

This block sits beside a two-port memory array and watches both ports. When both ports are enabled on the same address, it picks one port to lose. It drives that port's active-low busy line low and blocks that port's writes inside the block. The other port goes on normally. Timing is counted in clock cycles. The port whose access started in a later cycle is the one that loses. An access starts when the port's enable goes low, or when its address changes while it is enabled. If both ports start in the same cycle, the right port loses.

A mode input makes the block a master or a slave. As a master, it arbitrates and drives its busy outputs. As a slave, it drives both busy outputs high and uses busy inputs from an external master instead: a low busy input blocks writes on that port. The memory array itself is outside this block. The block only produces one write-enable qualifier per port, which the memory's write path uses.

Top module: `collide_arbiter`

## Requirements
- R1: In master mode, a busy output is low only in the cycle after a cycle in which both enables (active low) were low and the full addresses were equal. After any other cycle, both busy outputs are high.
- R2: On a new match, the port that started its access later gets busy low one clock later. An access starts in a cycle where enable was high before and is now low, or where the address differs from the previous cycle while enabled.
- R3: The two busy outputs are never low together.
- R4: A port's write qualifier is high only when that port is enabled and its write strobe is low. In master mode the qualifier is also low whenever that port's busy output is low, and whenever that port is the current loser of a match in the present cycle.
- R5: In slave mode, both busy outputs are high from the cycle after the mode is selected. A port's write qualifier then equals its request gated by its busy input: a low busy input blocks the write, and a high one lets it through.
- R6: Every one of the ADDR_W address bits is compared, so addresses that differ only in the top bit never raise busy.
- R7: If both ports start the matching access in the same cycle, the right port loses.
- R8: Busy returns high in the cycle after the match ends, whether the addresses part or either enable goes high.
- R9: While a match continues from cycle to cycle, the loser does not change, even if the winner re-presents the same address.
- R10: During and right after synchronous active-low reset, both busy outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_master | input | 1 | 1 = master, which arbitrates; 0 = slave, which obeys the busy inputs |
| left_en_n | input | 1 | Left port enable, active low |
| left_we_n | input | 1 | Left port write strobe, active low |
| left_addr | input | ADDR_W | Left port address |
| right_en_n | input | 1 | Right port enable, active low |
| right_we_n | input | 1 | Right port write strobe, active low |
| right_addr | input | ADDR_W | Right port address |
| left_busy_in_n | input | 1 | External busy for the left port, used in slave mode |
| right_busy_in_n | input | 1 | External busy for the right port, used in slave mode |
| left_busy_n | output | 1 | Left busy, active low |
| right_busy_n | output | 1 | Right busy, active low |
| left_wr_ok | output | 1 | Left write qualifier to the memory |
| right_wr_ok | output | 1 | Right write qualifier to the memory |

## Verification
A loser register holding a wrong value shows one clock later. Either busy points at the port that started first, or it flips while a match is still going on. A loser register left stuck after a match shows as busy that stays low for a cycle after the addresses part. A start-tracking register with a wrong value makes a same-cycle start look like a late one, so the tie case shows the wrong port busy. Broken gating shows in the same cycle as a write qualifier that is high while that port's busy is low.

// File: rtl/ca_pkg.sv
// Package: shared types for the collision arbiter.
// Assumes: two ports only; index 0 is left, index 1 is right.
package ca_pkg;
    typedef enum logic [1:0] {
        LOSER_NONE  = 2'b00,
        LOSER_LEFT  = 2'b01,
        LOSER_RIGHT = 2'b10
    } loser_e;

    localparam int NUM_PORTS = 2;
    localparam int PORT_L    = 0;
    localparam int PORT_R    = 1;
endpackage

// File: rtl/ca_port_track.sv
// Module: ca_port_track
// Flags the cycle in which one port starts a new access. A start is an
// enable that goes low, or an address change while the port is enabled.
// Assumes: active-low enable; synchronous active-low reset.
module ca_port_track #(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              fresh
);
    logic              prev_en_n;
    logic [ADDR_W-1:0] prev_addr;

    // Keep last cycle's enable and address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_en_n <= 1'b1;
            prev_addr <= '0;
        end else begin
            prev_en_n <= en_n;
            prev_addr <= addr;
        end
    end

    // Start of access: newly enabled, or a new address while enabled.
    always_comb begin
        fresh = !en_n && (prev_en_n || (addr != prev_addr));
    end
endmodule

// File: rtl/ca_judge.sv
// Module: ca_judge
// Finds address matches, picks the loser, keeps it fixed while the match
// lasts, and registers the active-low busy lines.
// Assumes: start flags come from ca_port_track; left wins on a tie.
module ca_judge
    import ca_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master,
    input  logic              l_en_n,
    input  logic              r_en_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              l_fresh,
    input  logic              r_fresh,
    output logic              lose_l,
    output logic              lose_r,
    output logic              busy_l_n,
    output logic              busy_r_n
);
    logic   match;
    logic   match_q;
    loser_e held_q;
    loser_e loser_now;

    // Full-width compare, qualified by both enables.
    always_comb begin
        match = !l_en_n && !r_en_n && (l_addr == r_addr);
    end

    // Pick the loser: keep the held one while the match goes on, else choose by start cycle.
    always_comb begin
        loser_now = LOSER_NONE;
        if (match) begin
            if (match_q && held_q != LOSER_NONE) begin
                loser_now = held_q;
            end else if (l_fresh && !r_fresh) begin
                loser_now = LOSER_LEFT;
            end else begin
                loser_now = LOSER_RIGHT;
            end
        end
    end

    // Record whether this cycle matched and who lost.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q <= 1'b0;
            held_q  <= LOSER_NONE;
        end else begin
            match_q <= match;
            held_q  <= loser_now;
        end
    end

    // Register busy lines; held high in slave mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_l_n <= 1'b1;
            busy_r_n <= 1'b1;
        end else begin
            busy_l_n <= !(master && loser_now == LOSER_LEFT);
            busy_r_n <= !(master && loser_now == LOSER_RIGHT);
        end
    end

    // Expose the current-cycle loser to the write gates.
    always_comb begin
        lose_l = (loser_now == LOSER_LEFT);
        lose_r = (loser_now == LOSER_RIGHT);
    end
endmodule

// File: rtl/ca_write_gate.sv
// Module: ca_write_gate
// Turns one port's write request into a write qualifier for the memory.
// Assumes: master mode gates by local arbitration; slave mode by busy input.
module ca_write_gate (
    input  logic master,
    input  logic en_n,
    input  logic we_n,
    input  logic busy_q_n,
    input  logic lose_now,
    input  logic busy_in_n,
    output logic wr_ok
);
    logic req;

    // Request, then gate it according to the mode.
    always_comb begin
        req = !en_n && !we_n;
        if (master) begin
            wr_ok = req && busy_q_n && !lose_now;
        end else begin
            wr_ok = req && busy_in_n;
        end
    end
endmodule

// File: rtl/collide_arbiter.sv
// Module: collide_arbiter (top)
// Busy arbitration on address collisions for a two-port memory. One start
// tracker per port (generate), one judge, and one write gate per port.
// Assumes: synchronous active-low reset; the memory array is outside.
module collide_arbiter
    import ca_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_master,
    input  logic              left_en_n,
    input  logic              left_we_n,
    input  logic [ADDR_W-1:0] left_addr,
    input  logic              right_en_n,
    input  logic              right_we_n,
    input  logic [ADDR_W-1:0] right_addr,
    input  logic              left_busy_in_n,
    input  logic              right_busy_in_n,
    output logic              left_busy_n,
    output logic              right_busy_n,
    output logic              left_wr_ok,
    output logic              right_wr_ok
);
    logic [NUM_PORTS-1:0]             en_n_v;
    logic [NUM_PORTS-1:0]             we_n_v;
    logic [NUM_PORTS-1:0][ADDR_W-1:0] addr_v;
    logic [NUM_PORTS-1:0]             bin_v;
    logic [NUM_PORTS-1:0]             fresh_v;
    logic [NUM_PORTS-1:0]             lose_v;
    logic [NUM_PORTS-1:0]             busy_v;
    logic [NUM_PORTS-1:0]             wrok_v;

    // Gather the per-port signals into vectors.
    always_comb begin
        en_n_v[PORT_L] = left_en_n;
        en_n_v[PORT_R] = right_en_n;
        we_n_v[PORT_L] = left_we_n;
        we_n_v[PORT_R] = right_we_n;
        addr_v[PORT_L] = left_addr;
        addr_v[PORT_R] = right_addr;
        bin_v[PORT_L]  = left_busy_in_n;
        bin_v[PORT_R]  = right_busy_in_n;
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        ca_port_track #(.ADDR_W(ADDR_W)) u_track (
            .clk   (clk),
            .rst_n (rst_n),
            .en_n  (en_n_v[p]),
            .addr  (addr_v[p]),
            .fresh (fresh_v[p])
        );

        ca_write_gate u_gate (
            .master    (mode_master),
            .en_n      (en_n_v[p]),
            .we_n      (we_n_v[p]),
            .busy_q_n  (busy_v[p]),
            .lose_now  (lose_v[p]),
            .busy_in_n (bin_v[p]),
            .wr_ok     (wrok_v[p])
        );
    end

    ca_judge #(.ADDR_W(ADDR_W)) u_judge (
        .clk      (clk),
        .rst_n    (rst_n),
        .master   (mode_master),
        .l_en_n   (left_en_n),
        .r_en_n   (right_en_n),
        .l_addr   (left_addr),
        .r_addr   (right_addr),
        .l_fresh  (fresh_v[PORT_L]),
        .r_fresh  (fresh_v[PORT_R]),
        .lose_l   (lose_v[PORT_L]),
        .lose_r   (lose_v[PORT_R]),
        .busy_l_n (busy_v[PORT_L]),
        .busy_r_n (busy_v[PORT_R])
    );

    // Drive the outputs from the per-port vectors.
    always_comb begin
        left_busy_n  = busy_v[PORT_L];
        right_busy_n = busy_v[PORT_R];
        left_wr_ok   = wrok_v[PORT_L];
        right_wr_ok  = wrok_v[PORT_R];
    end
endmodule

// File: rtl/ca_checker.sv
// Module: ca_checker
// Port-level properties of collide_arbiter, attached with bind.
// Assumes: it sees only the top module's ports.
module ca_checker #(
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_master,
    input logic              left_en_n,
    input logic              left_we_n,
    input logic [ADDR_W-1:0] left_addr,
    input logic              right_en_n,
    input logic              right_we_n,
    input logic [ADDR_W-1:0] right_addr,
    input logic              left_busy_in_n,
    input logic              right_busy_in_n,
    input logic              left_busy_n,
    input logic              right_busy_n,
    input logic              left_wr_ok,
    input logic              right_wr_ok
);
    logic       hit;
    logic [1:0] age;

    // Port-level view of a collision.
    always_comb begin
        hit = !left_en_n && !right_en_n && (left_addr == right_addr);
    end

    // Count cycles since reset, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n) age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    a_r3_not_both_low: assert property (@(posedge clk) disable iff (!rst_n)
        !(!left_busy_n && !right_busy_n));

    a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> (left_busy_n && right_busy_n));

    a_r4_left_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_master && !left_busy_n) |-> !left_wr_ok);

    a_r4_right_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_master && !right_busy_n) |-> !right_wr_ok);

    a_r5_slave_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_master && (!left_busy_in_n || left_en_n || left_we_n)) |-> !left_wr_ok);

    a_r5_slave_high: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 2'd0 && !mode_master && $past(!mode_master))
            |-> (left_busy_n && right_busy_n));

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3 && mode_master && $past(mode_master) && hit && $past(hit))
            |=> $stable(left_busy_n));
endmodule

bind collide_arbiter ca_checker #(.ADDR_W(ADDR_W)) u_ca_checker (.*);

// File: tb/collide_arbiter_tb_top.sv
// Testbench: vector table walked by a loop, then directed tests.
module collide_arbiter_tb_top;
    localparam int ADDR_W = 15;

    typedef struct packed {
        logic       le_n;
        logic       lw_n;
        logic [3:0] la;
        logic       re_n;
        logic       rw_n;
        logic [3:0] ra;
        logic       ewl;
        logic       ewr;
        logic       ebl;
        logic       ebr;
    } vec_t;

    localparam int NV = 11;
    // Fields: L en_n, L we_n, L addr, R en_n, R we_n, R addr, exp wr_ok L/R (pre-edge), exp busy L/R (post-edge)
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,4'd5, 1'b1,1'b1,4'd0, 1'b1,1'b0, 1'b1,1'b1}, // R1 only left
        '{1'b0,1'b0,4'd5, 1'b0,1'b0,4'd5, 1'b1,1'b0, 1'b1,1'b0}, // R2 right later loses
        '{1'b0,1'b0,4'd5, 1'b0,1'b0,4'd5, 1'b1,1'b0, 1'b1,1'b0}, // R9 held
        '{1'b0,1'b0,4'd6, 1'b0,1'b0,4'd5, 1'b1,1'b0, 1'b1,1'b1}, // R8 release, R4 busy gate
        '{1'b1,1'b1,4'd0, 1'b1,1'b1,4'd0, 1'b0,1'b0, 1'b1,1'b1}, // idle
        '{1'b0,1'b0,4'd9, 1'b0,1'b0,4'd9, 1'b1,1'b0, 1'b1,1'b0}, // R7 tie, right loses
        '{1'b0,1'b0,4'd9, 1'b0,1'b0,4'd3, 1'b1,1'b0, 1'b1,1'b1}, // R8
        '{1'b0,1'b0,4'd3, 1'b0,1'b0,4'd3, 1'b0,1'b1, 1'b0,1'b1}, // R2 left later loses
        '{1'b0,1'b0,4'd3, 1'b0,1'b1,4'd3, 1'b0,1'b0, 1'b0,1'b1}, // R9 held, right reads
        '{1'b0,1'b0,4'd3, 1'b1,1'b1,4'd3, 1'b0,1'b0, 1'b1,1'b1}, // R8 enable high, R4 busy gate
        '{1'b0,1'b0,4'd3, 1'b1,1'b1,4'd3, 1'b1,1'b0, 1'b1,1'b1}  // R4 free again
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              mode_master = 1'b1;
    logic              left_en_n = 1'b1, left_we_n = 1'b1;
    logic              right_en_n = 1'b1, right_we_n = 1'b1;
    logic [ADDR_W-1:0] left_addr = '0, right_addr = '0;
    logic              left_busy_in_n = 1'b1, right_busy_in_n = 1'b1;
    logic              left_busy_n, right_busy_n, left_wr_ok, right_wr_ok;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    collide_arbiter #(.ADDR_W(ADDR_W)) dut_i (.*);

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic drive(input logic le, input logic lw, input logic [ADDR_W-1:0] la,
                         input logic re, input logic rw, input logic [ADDR_W-1:0] ra);
        left_en_n = le; left_we_n = lw; left_addr = la;
        right_en_n = re; right_we_n = rw; right_addr = ra;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1;
        chk("R10 left busy in reset", left_busy_n, 1'b1);
        chk("R10 right busy in reset", right_busy_n, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;

        // Vector table, master mode
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VECS[i].le_n, VECS[i].lw_n, ADDR_W'(VECS[i].la),
                  VECS[i].re_n, VECS[i].rw_n, ADDR_W'(VECS[i].ra));
            #1;
            chk($sformatf("R4 left wr_ok vec %0d", i), left_wr_ok, VECS[i].ewl);
            chk($sformatf("R4 right wr_ok vec %0d", i), right_wr_ok, VECS[i].ewr);
            @(posedge clk);
            #1;
            chk($sformatf("R1/R2/R7/R8/R9 left busy vec %0d", i), left_busy_n, VECS[i].ebl);
            chk($sformatf("R1/R2/R7/R8/R9 right busy vec %0d", i), right_busy_n, VECS[i].ebr);
            chk($sformatf("R3 never both low vec %0d", i), !left_busy_n && !right_busy_n, 1'b0);
        end

        // R6: addresses differ only in the top bit
        @(negedge clk);
        drive(1'b1, 1'b1, '0, 1'b1, 1'b1, '0);
        @(negedge clk);
        drive(1'b0, 1'b0, '0, 1'b0, 1'b0, ADDR_W'(1) << (ADDR_W - 1));
        #1;
        chk("R6 left write allowed", left_wr_ok, 1'b1);
        chk("R6 right write allowed", right_wr_ok, 1'b1);
        @(posedge clk); #1;
        chk("R6 left busy high", left_busy_n, 1'b1);
        chk("R6 right busy high", right_busy_n, 1'b1);

        // R10: reset in the middle of a conflict
        @(negedge clk);
        drive(1'b0, 1'b0, ADDR_W'(7), 1'b0, 1'b0, ADDR_W'(7));
        @(posedge clk); #1;
        chk("R2 setup conflict right busy", right_busy_n, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk); #1;
        chk("R10 right busy after reset", right_busy_n, 1'b1);
        chk("R10 left busy after reset", left_busy_n, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;
        drive(1'b1, 1'b1, '0, 1'b1, 1'b1, '0);

        // R5: slave mode
        @(negedge clk);
        mode_master = 1'b0;
        drive(1'b0, 1'b0, ADDR_W'(4), 1'b0, 1'b0, ADDR_W'(4));
        left_busy_in_n = 1'b0;
        right_busy_in_n = 1'b1;
        #1;
        chk("R5 slave left inhibited", left_wr_ok, 1'b0);
        chk("R5 slave right allowed", right_wr_ok, 1'b1);
        @(posedge clk); #1;
        chk("R5 slave left busy out high", left_busy_n, 1'b1);
        chk("R5 slave right busy out high", right_busy_n, 1'b1);
        @(negedge clk);
        left_busy_in_n = 1'b1;
        right_busy_in_n = 1'b0;
        #1;
        chk("R5 slave left allowed", left_wr_ok, 1'b1);
        chk("R5 slave right inhibited", right_wr_ok, 1'b0);

        @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule